// File: doc/BRIEF.md
# Programmable Watchdog With Reset Steering

This block is a watchdog timer configured through one 8-bit control byte. The byte holds a multiplier and a resolution code; together they give the timeout as a count of strobes from an external 1/16-second time base. The top bit of the byte picks what expiry does. It can raise a system reset request, which also wipes the control byte and asks a neighbouring register to drop one of its bits. Otherwise it raises a single interrupt pulse.

Software keeps the watchdog alive in two ways. It can rewrite the control byte, or it can read the status (flags) register. Either action reloads the count and clears the watchdog flag. The block only sees these accesses as strobes, already decoded by the bus logic around it.

The core is a three-state machine. WD_OFF means no timeout is loaded. WD_COUNT means ticks are being counted down. WD_EXPIRED means the count ran out and the block waits for a restart. The transitions are:
- restart_to_count: any state goes to WD_COUNT when a restart loads a nonzero interval.
- restart_to_off: any state goes to WD_OFF when a restart loads an interval of zero.
- count_expire: WD_COUNT goes to WD_EXPIRED on the final tick.
- hold: every other case keeps the current state.

Top module: `steered_watchdog`

## Requirements
- R1: After reset the control byte reads 0x00, the watchdog flag is 0, and the reset request, interrupt and clear-request outputs are 0.
- R2: The control byte is laid out as follows. Bit 7 is the steer bit, bits 6:2 are the multiplier M, and bits 1:0 are the resolution code S. The timeout is M times 4 to the power S ticks. After a restart, expiry happens on exactly the M·4^S-th tick strobe, and no pulse or flag appears before it.
- R3: A control write stores the byte, readable on `wd_reg_o` the next cycle. It restarts the count from the new value and clears the watchdog flag.
- R4: A flags-read strobe restarts the count using the stored control byte and clears the watchdog flag.
- R5: Expiry sets the watchdog flag. The flag stays set until the next restart.
- R6: Expiry with the steer bit at 1 gives a one-cycle reset request and a one-cycle clear request in the same cycle, with no interrupt. It also clears the control byte to 0x00.
- R7: Expiry with the steer bit at 0 gives a one-cycle interrupt with no reset request, and leaves the control byte unchanged.
- R8: A multiplier of zero disables the watchdog. No expiry follows, however many ticks arrive, until a nonzero value is loaded.
- R9: After an expiry the count stops. Further ticks produce no pulse until a restart.
- R10: A restart in the same cycle as the tick that would expire the count takes priority. No expiry occurs, and the full interval starts again.
- R11: When a control write and a flags read happen in the same cycle, the written value is the one loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe every 1/16 second |
| wd_we_i | input | 1 | Control byte write strobe |
| wd_wdata_i | input | 8 | Control byte write data |
| flags_rd_i | input | 1 | Flags register read strobe |
| wd_reg_o | output | 8 | Stored control byte |
| wd_flag_o | output | 1 | Watchdog flag (bit 7 of the flags register) |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | One-cycle interrupt pulse |
| aux_clr_o | output | 1 | One-cycle request to clear bit 6 of the neighbouring control register |

## Verification
On every cycle, the assertions check the following:
- The reset request and the interrupt are never high together.
- Each of them lasts a single cycle.
- A reset request coincides with a cleared control byte and a set flag.
- Restarts clear the flag.
- An interrupt never follows a disabled configuration.

The exact expiry cycle for each multiplier and resolution pair can only be shown by the bench's sweeps. The same holds for the halt after expiry, the restart-versus-final-tick priority, and the write-over-read ordering.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        WD_OFF      = 2'd0,
        WD_COUNT    = 2'd1,
        WD_EXPIRED  = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             clr,
    output logic [REG_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (we)  q <= wdata;
        else if (clr) q <= '0;
    end
endmodule

// File: rtl/wdt_interval.sv
module wdt_interval #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int CNT_W  = 11
) (
    input  logic [MULT_W-1:0] mult,
    input  logic [RES_W-1:0]  res,
    output logic [CNT_W-1:0]  ticks
);
    // Resolution step is a factor of four: shift by twice the code.
    always_comb begin
        ticks = CNT_W'(mult) << {res, 1'b0};
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - CNT_W'(1);
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/steered_watchdog.sv
module steered_watchdog
    import wdt_pkg::*;
#(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic                       wd_we_i,
    input  logic [MULT_W+RES_W:0]      wd_wdata_i,
    input  logic                       flags_rd_i,
    output logic [MULT_W+RES_W:0]      wd_reg_o,
    output logic                       wd_flag_o,
    output logic                       rst_req_o,
    output logic                       irq_o,
    output logic                       aux_clr_o
);
    localparam int REG_W   = MULT_W + RES_W + 1;
    localparam int STEER_B = REG_W - 1;
    localparam int CNT_W   = MULT_W + 2 * ((1 << RES_W) - 1);

    wd_state_e        state_q, state_d;
    logic             restart, expire, cnt_last;
    logic [REG_W-1:0] src_byte;
    logic [CNT_W-1:0] load_ticks;
    logic             flag_q, rst_q, irq_q;

    assign restart  = wd_we_i | flags_rd_i;
    // A write in the same cycle as a read supplies the value loaded.
    assign src_byte = wd_we_i ? wd_wdata_i : wd_reg_o;
    assign expire   = (state_q == WD_COUNT) && tick_i && cnt_last && !restart;

    wdt_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wd_we_i),
        .wdata (wd_wdata_i),
        .clr   (expire && wd_reg_o[STEER_B]),
        .q     (wd_reg_o)
    );

    wdt_interval #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_ivl (
        .mult  (src_byte[RES_W +: MULT_W]),
        .res   (src_byte[RES_W-1:0]),
        .ticks (load_ticks)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (restart),
        .load_val (load_ticks),
        .dec      ((state_q == WD_COUNT) && tick_i && !restart),
        .last     (cnt_last)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = (load_ticks == '0) ? WD_OFF : WD_COUNT;
        end else begin
            unique case (state_q)
                WD_OFF:     state_d = WD_OFF;
                WD_COUNT:   state_d = expire ? WD_EXPIRED : WD_COUNT;
                WD_EXPIRED: state_d = WD_EXPIRED;
                default:    state_d = WD_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            rst_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            rst_q <= expire &&  wd_reg_o[STEER_B];
            irq_q <= expire && !wd_reg_o[STEER_B];
            if (restart)     flag_q <= 1'b0;
            else if (expire) flag_q <= 1'b1;
        end
    end

    assign wd_flag_o = flag_q;
    assign rst_req_o = rst_q;
    assign aux_clr_o = rst_q;
    assign irq_o     = irq_q;
endmodule

// File: rtl/wdt_checks.sv
module wdt_checks #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wd_we_i,
    input logic [MULT_W+RES_W:0] wd_wdata_i,
    input logic                  flags_rd_i,
    input logic [MULT_W+RES_W:0] wd_reg_o,
    input logic                  wd_flag_o,
    input logic                  rst_req_o,
    input logic                  irq_o,
    input logic                  aux_clr_o
);
    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_req_o, irq_o}));
    p_rst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);
    p_rst_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (wd_reg_o == '0) && aux_clr_o);
    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    p_irq_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !wd_reg_o[MULT_W+RES_W]);
    p_flag_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o || irq_o) |-> wd_flag_o);
    p_write_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wd_we_i |=> (wd_reg_o == $past(wd_wdata_i)) && !wd_flag_o);
    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flags_rd_i |=> !wd_flag_o);
    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(wd_reg_o[RES_W +: MULT_W]) != '0));
endmodule

bind steered_watchdog wdt_checks #(.MULT_W(MULT_W), .RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wd_we_i    (wd_we_i),
    .wd_wdata_i (wd_wdata_i),
    .flags_rd_i (flags_rd_i),
    .wd_reg_o   (wd_reg_o),
    .wd_flag_o  (wd_flag_o),
    .rst_req_o  (rst_req_o),
    .irq_o      (irq_o),
    .aux_clr_o  (aux_clr_o)
);

// File: tb/sim_steered_watchdog.sv
module sim_steered_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, we = 1'b0, rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] reg_o;
    logic       flag, rst_req, irq, aux_clr;
    int         n_tests = 0, n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    steered_watchdog u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wd_we_i(we),
        .wd_wdata_i(wdata), .flags_rd_i(rd), .wd_reg_o(reg_o),
        .wd_flag_o(flag), .rst_req_o(rst_req), .irq_o(irq), .aux_clr_o(aux_clr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, sample 1 time unit after the rising edge.
    task automatic step(input bit t, input bit w, input logic [7:0] d, input bit r);
        @(negedge clk);
        tick = t; we = w; wdata = d; rd = r;
        @(posedge clk);
        #1;
        tick = 1'b0; we = 1'b0; rd = 1'b0;
    endtask

    function automatic int span(input logic [7:0] v);
        return int'(v[6:2]) << (2 * int'(v[1:0]));
    endfunction

    // Count n ticks, return 1 if any pulse or flag appeared before the last; last sampled after tick n.
    task automatic run_ticks(input int n, output bit early);
        early = 1'b0;
        for (int k = 1; k <= n; k++) begin
            step(1'b1, 1'b0, 8'h00, 1'b0);
            if (k < n && (rst_req || irq || flag)) early = 1'b1;
        end
    endtask

    initial begin : wd_timer
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit early;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        chk(reg_o == 8'h00 && !flag && !rst_req && !irq && !aux_clr, "R1 reset state",
            {reg_o, flag, rst_req, irq, aux_clr}, 0);

        // R2/R5/R6/R7/R9: sweep every nonzero multiplier and every resolution
        for (int m = 1; m < 32; m++) begin
            for (int r = 0; r < 4; r++) begin
                logic [7:0] v;
                int n;
                v = {1'(((m + r) % 2)), 5'(m), 2'(r)};
                n = span(v);
                step(1'b0, 1'b1, v, 1'b0);
                chk(reg_o == v && !flag, "R3 write stores", reg_o, v);
                run_ticks(n, early);
                chk(!early, "R2 no early expiry", early, 0);
                if (v[7]) begin
                    chk(rst_req && aux_clr && !irq, "R6 reset steer", {rst_req, aux_clr, irq}, 3'b110);
                    chk(reg_o == 8'h00, "R6 byte cleared", reg_o, 0);
                end else begin
                    chk(irq && !rst_req && !aux_clr, "R7 irq steer", {rst_req, aux_clr, irq}, 3'b001);
                    chk(reg_o == v, "R7 byte kept", reg_o, v);
                end
                chk(flag, "R5 flag set", flag, 1);
                run_ticks(3, early);
                chk(!rst_req && !irq && flag, "R9 halted", {rst_req, irq, flag}, 3'b001);
                if (!v[7] && r < 2) begin
                    step(1'b0, 1'b0, 8'h00, 1'b1);
                    chk(!flag, "R4 read clears flag", flag, 0);
                    run_ticks(n, early);
                    chk(!early && irq && flag, "R4 read restart", {early, irq, flag}, 3'b011);
                end
            end
        end

        // R8: zero multiplier disables expiry
        step(1'b0, 1'b1, 8'h83, 1'b0);
        run_ticks(300, early);
        chk(!early && !rst_req && !irq && !flag, "R8 disabled", {rst_req, irq, flag}, 0);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        run_ticks(50, early);
        chk(!rst_req && !irq && reg_o == 8'h83, "R8 read keeps disabled", {rst_req, irq}, 0);

        // R3: rewrite mid-count restarts the full interval (M=3, S=0)
        step(1'b0, 1'b1, 8'h0C, 1'b0);
        run_ticks(2, early);
        step(1'b0, 1'b1, 8'h0C, 1'b0);
        run_ticks(3, early);
        chk(!early && irq, "R3 rewrite restarts", {early, irq}, 2'b01);

        // R10: restart with the final tick wins (M=1, S=0)
        step(1'b0, 1'b1, 8'h04, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b1);
        chk(!irq && !flag, "R10 read beats last tick", {irq, flag}, 0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk(irq && flag, "R10 full interval after", {irq, flag}, 2'b11);
        step(1'b0, 1'b1, 8'h04, 1'b0);
        step(1'b1, 1'b1, 8'h84, 1'b0);
        chk(!irq && !rst_req && reg_o == 8'h84, "R10 write beats last tick", {irq, rst_req}, 0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk(rst_req && reg_o == 8'h00, "R10 reset after reload", rst_req, 1);

        // R11: write and read together load the written value (M=2, S=0)
        step(1'b0, 1'b1, 8'h7F, 1'b0);
        step(1'b0, 1'b1, 8'h08, 1'b1);
        chk(reg_o == 8'h08, "R11 write wins store", reg_o, 8'h08);
        run_ticks(2, early);
        chk(!early && irq, "R11 written interval", {early, irq}, 2'b01);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule